// File: doc/BRIEF.md
# Host I/O Base-Address Claim Decoder

This block sits behind the host I/O cycle decoder of an embedded controller. A bank of programmable base address registers (BARs) describes where each logical device lives in the 16-bit host I/O space. When a host I/O address is presented with its strobe, every BAR compares the address in parallel. Each BAR has its own don't-care mask, and a BAR takes part only when its valid bit is set. The lowest-numbered matching BAR wins.

On a hit the block raises a claim flag and reports the logical device number held in the winning BAR. It then steers the cycle. A hit on the reserved configuration device number goes to the configuration port. Any other device goes to that device's runtime register window, together with a 7-bit register offset inside the window. Firmware programs the BARs through a simple indexed write port. After reset no BAR is valid, so nothing is claimed.

Top module: `lpc_io_claim`

## Requirements
- R1: The BAR word layout is: bits 31:16 base I/O address, bit 15 valid, bit 14 unused, bits 13:8 logical device number, bits 7:0 mask. A write with `bar_wr_en` high stores `bar_wr_data` into BAR `bar_wr_idx`. The new value is used by lookups strobed in the following cycle and later. A lookup strobed in the same cycle as the write still sees the old value.
- R2: Address `A` hits BAR `b` when `(A & ~M) == (B & ~M)` and the BAR is valid. Here `B` is the base address and `M` is the 8-bit mask zero-extended to 16 bits. All address bits from 8 upward are therefore always compared.
- R3: A BAR with its valid bit clear never claims. Reset clears the valid bit of every BAR.
- R4: A valid BAR with base 0x0060 and mask 0x04 claims exactly the addresses 0x0060 and 0x0064.
- R5: When several BARs hit, the one with the lowest index decides the result.
- R6: On a claim, `dev_id` equals bits 13:8 of the winning BAR.
- R7: On a claim, exactly one of `to_cfg` and `to_runtime` is high. `to_cfg` is high only when `dev_id` is 0x0C.
- R8: On a claim, `reg_offset` equals `io_addr[6:0] & mask[6:0]` of the winning BAR.
- R9: All outputs are registered. The result for an address strobed by `io_valid` appears on the next clock edge and lasts one cycle. A cycle without `io_valid` yields all outputs zero on the next edge.
- R10: When `io_valid` is high and no BAR hits, `claim`, `to_cfg`, `to_runtime`, `dev_id` and `reg_offset` are all zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_wr_en | input | 1 | BAR write strobe |
| bar_wr_idx | input | 3 | Index of the BAR to write |
| bar_wr_data | input | 32 | BAR word to store |
| io_valid | input | 1 | Host I/O address strobe |
| io_addr | input | 16 | Host I/O cycle address |
| claim | output | 1 | Cycle claimed by a BAR |
| dev_id | output | 6 | Logical device number of the winning BAR |
| to_cfg | output | 1 | Cycle routed to the configuration port |
| to_runtime | output | 1 | Cycle routed to a runtime register window |
| reg_offset | output | 7 | Register offset inside the runtime window |

## Verification
The main sweep strobes all 65536 I/O addresses back to back against a bank that holds several kinds of BAR. The bank includes the two-address mask case and a wide-masked window that overlaps a lower-indexed BAR, which tells the priority order apart from simple any-hit logic. It also has a configuration-port BAR, a BAR whose only mask bit is bit 7, and a valid-clear BAR at an otherwise matching address. Further stimulus covers the reset state, a strobe-free cycle, a BAR invalidated by a rewrite, and a write that coincides with a lookup of the same address. Together these tell old-value from new-value timing apart.

// File: rtl/lpc_bar_pkg.sv
package lpc_bar_pkg;

    parameter int NUM_BARS  = 8;
    parameter int ADDR_W    = 16;
    parameter int MASK_W    = 8;
    parameter int DEV_W     = 6;
    parameter int OFFSET_W  = 7;
    parameter int BAR_W     = 32;

    localparam logic [DEV_W-1:0] CFG_PORT_DEV = 6'h0C;

    // BAR word: base[31:16], valid[15], spare[14], device[13:8], mask[7:0]
    typedef struct packed {
        logic [ADDR_W-1:0] io_base;
        logic              valid;
        logic              spare;
        logic [DEV_W-1:0]  dev;
        logic [MASK_W-1:0] mask;
    } bar_t;

    typedef struct packed {
        logic                claim;
        logic                to_cfg;
        logic                to_rt;
        logic [DEV_W-1:0]    dev;
        logic [OFFSET_W-1:0] offset;
    } route_t;

    function automatic logic bar_hit(bar_t b, logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] care;
        care = ~{{(ADDR_W-MASK_W){1'b0}}, b.mask};
        return b.valid && ((a & care) == (b.io_base & care));
    endfunction

    function automatic logic [OFFSET_W-1:0] win_offset(bar_t b, logic [ADDR_W-1:0] a);
        return a[OFFSET_W-1:0] & b.mask[OFFSET_W-1:0];
    endfunction

endpackage

// File: rtl/lpc_bar_bank.sv
module lpc_bar_bank
    import lpc_bar_pkg::*;
#(
    parameter int N     = NUM_BARS,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BAR_W-1:0] wr_data,
    output bar_t [N-1:0]     bars
);

    bar_t [N-1:0] bar_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bar_q <= '0;
        end else if (wr_en) begin
            bar_q[wr_idx] <= bar_t'(wr_data);
        end
    end

    assign bars = bar_q;

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> (bars[$past(wr_idx)] == bar_t'($past(wr_data))));

    generate
        for (genvar g = 0; g < N; g++) begin : g_rst_chk
            assert_reset_clears_valid_R3: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> !bars[g].valid);
        end
    endgenerate

endmodule

// File: rtl/lpc_bar_match.sv
module lpc_bar_match
    import lpc_bar_pkg::*;
#(
    parameter int N = NUM_BARS
) (
    input  bar_t [N-1:0]      bars,
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      hits
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign hits[g] = bar_hit(bars[g], addr);
        end
    endgenerate

endmodule

// File: rtl/lpc_bar_prio.sv
module lpc_bar_prio
    import lpc_bar_pkg::*;
#(
    parameter int N     = NUM_BARS,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     hits,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx,
    output logic [N-1:0]     grant
);

    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        grant = '0;
        if (any_hit) grant[win_idx] = 1'b1;
    end

    assert_grant_single_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~hits) == '0));

    assert_grant_lowest_R5: assert property (@(posedge clk) disable iff (rst)
        ((((grant - 1'b1) & hits) == '0)));

    assert_any_iff_hit_R5: assert property (@(posedge clk) disable iff (rst)
        any_hit == (hits != '0));

endmodule

// File: rtl/lpc_io_claim.sv
module lpc_io_claim
    import lpc_bar_pkg::*;
#(
    parameter int N     = NUM_BARS,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bar_wr_en,
    input  logic [IDX_W-1:0]    bar_wr_idx,
    input  logic [BAR_W-1:0]    bar_wr_data,
    input  logic                io_valid,
    input  logic [ADDR_W-1:0]   io_addr,
    output logic                claim,
    output logic [DEV_W-1:0]    dev_id,
    output logic                to_cfg,
    output logic                to_runtime,
    output logic [OFFSET_W-1:0] reg_offset
);

    bar_t [N-1:0]     bars;
    logic [N-1:0]     hits;
    logic [N-1:0]     grant;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    bar_t             win_bar;
    route_t           route_d;
    route_t           route_q;

    lpc_bar_bank #(.N(N)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bar_wr_en),
        .wr_idx  (bar_wr_idx),
        .wr_data (bar_wr_data),
        .bars    (bars)
    );

    lpc_bar_match #(.N(N)) i_match (
        .bars (bars),
        .addr (io_addr),
        .hits (hits)
    );

    lpc_bar_prio #(.N(N)) i_prio (
        .clk     (clk),
        .rst     (rst),
        .hits    (hits),
        .any_hit (any_hit),
        .win_idx (win_idx),
        .grant   (grant)
    );

    assign win_bar = bars[win_idx];

    always_comb begin
        route_d = '0;
        if (io_valid && any_hit) begin
            route_d.claim  = 1'b1;
            route_d.dev    = win_bar.dev;
            route_d.offset = win_offset(win_bar, io_addr);
            route_d.to_cfg = (win_bar.dev == CFG_PORT_DEV);
            route_d.to_rt  = (win_bar.dev != CFG_PORT_DEV);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) route_q <= '0;
        else     route_q <= route_d;
    end

    assign claim      = route_q.claim;
    assign dev_id     = route_q.dev;
    assign to_cfg     = route_q.to_cfg;
    assign to_runtime = route_q.to_rt;
    assign reg_offset = route_q.offset;

    assert_claim_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        claim |-> $past(io_valid));

    assert_claim_needs_grant_R9: assert property (@(posedge clk) disable iff (rst)
        claim |-> ($past(grant) != '0));

    assert_route_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({to_cfg, to_runtime}) && (claim == (to_cfg | to_runtime)));

    assert_cfg_device_R7: assert property (@(posedge clk) disable iff (rst)
        to_cfg |-> (dev_id == CFG_PORT_DEV));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !claim |-> (dev_id == '0 && reg_offset == '0));

endmodule

// File: tb/test_lpc_io_claim.sv
module test_lpc_io_claim;
    import lpc_bar_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        bar_wr_en;
    logic [2:0]  bar_wr_idx;
    logic [31:0] bar_wr_data;
    logic        io_valid;
    logic [15:0] io_addr;
    logic        claim;
    logic [5:0]  dev_id;
    logic        to_cfg;
    logic        to_runtime;
    logic [6:0]  reg_offset;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_bar [8];

    always #5 clk = ~clk;

    lpc_io_claim i_lpc_io_claim (
        .clk(clk), .rst(rst), .bar_wr_en(bar_wr_en), .bar_wr_idx(bar_wr_idx),
        .bar_wr_data(bar_wr_data), .io_valid(io_valid), .io_addr(io_addr),
        .claim(claim), .dev_id(dev_id), .to_cfg(to_cfg), .to_runtime(to_runtime),
        .reg_offset(reg_offset)
    );

    function automatic logic [31:0] mk_bar(logic [15:0] base, logic v, logic [5:0] dev, logic [7:0] m);
        return {base, v, 1'b0, dev, m};
    endfunction

    // packed {claim, to_cfg, to_rt, dev[5:0], off[6:0]}
    function automatic logic [15:0] expect_for(logic vld, logic [15:0] a);
        logic [15:0] r;
        r = '0;
        if (vld) begin
            for (int i = 7; i >= 0; i--) begin
                logic [15:0] base;
                logic [15:0] m;
                base = model_bar[i][31:16];
                m    = {8'h00, model_bar[i][7:0]};
                if (model_bar[i][15] && ((a | m) == (base | m))) begin
                    r = {1'b1, (model_bar[i][13:8] == 6'd12), (model_bar[i][13:8] != 6'd12),
                         model_bar[i][13:8], a[6:0] & model_bar[i][6:0]};
                end
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [15:0] exp, logic [15:0] addr);
        logic [15:0] act;
        act = {claim, to_cfg, to_runtime, dev_id, reg_offset};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    task automatic write_bar(int idx, logic [31:0] data);
        @(negedge clk);
        bar_wr_en = 1'b1; bar_wr_idx = 3'(idx); bar_wr_data = data;
        model_bar[idx] = data;
        @(negedge clk);
        bar_wr_en = 1'b0;
    endtask

    task automatic lookup(string req, logic [15:0] a);
        @(negedge clk);
        io_valid = 1'b1; io_addr = a;
        @(negedge clk);
        io_valid = 1'b0;
        check(req, expect_for(1'b1, a), a);
    endtask

    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model_bar[i] = '0;
        rst = 1'b1; bar_wr_en = 1'b0; bar_wr_idx = '0; bar_wr_data = '0;
        io_valid = 1'b0; io_addr = '0;
        repeat (3) @(negedge clk);
        // reset state: all outputs zero (R10)
        check("R10 reset", 16'h0000, 16'h0);
        rst = 1'b0;
        // R3: nothing claimed after reset
        lookup("R3 after reset", 16'h0000);
        lookup("R3 after reset", 16'h0060);

        write_bar(0, mk_bar(16'h0060, 1'b1, 6'h01, 8'h04));
        write_bar(1, mk_bar(16'h0238, 1'b1, 6'h03, 8'h47));
        write_bar(2, mk_bar(16'h002E, 1'b1, 6'h0C, 8'h01));
        write_bar(3, mk_bar(16'h0230, 1'b1, 6'h05, 8'h0F));
        write_bar(4, mk_bar(16'h1000, 1'b1, 6'h3F, 8'h80));
        write_bar(5, mk_bar(16'h0080, 1'b0, 6'h07, 8'h00));

        // R4 explicit points
        lookup("R4 0x60", 16'h0060);
        lookup("R4 0x64", 16'h0064);
        lookup("R4 0x61", 16'h0061);
        lookup("R4 0x68", 16'h0068);
        lookup("R4 0x160", 16'h0160);
        // R5 overlap, R8 offset, R7 config port, R3 invalid
        lookup("R5 overlap", 16'h023D);
        lookup("R5 upper only", 16'h0233);
        lookup("R8 mirror", 16'h027A);
        lookup("R7 cfg", 16'h002F);
        lookup("R3 invalid bar", 16'h0080);
        lookup("R2 bit7 mask", 16'h1080);

        // full streaming sweep (R2 R4 R5 R6 R7 R8 R10)
        @(negedge clk);
        io_valid = 1'b1; io_addr = 16'h0000;
        for (int a = 1; a <= 65536; a++) begin
            logic [15:0] prev;
            prev = io_addr;
            @(negedge clk);
            check("R2 sweep", expect_for(1'b1, prev), prev);
            if (a < 65536) io_addr = 16'(a);
            else io_valid = 1'b0;
        end

        // R9: no strobe, matching address present
        @(negedge clk);
        io_valid = 1'b0; io_addr = 16'h0060;
        @(negedge clk);
        check("R9 no strobe", 16'h0000, 16'h0060);

        // R3: invalidate BAR0 by rewrite
        write_bar(0, mk_bar(16'h0060, 1'b0, 6'h01, 8'h04));
        lookup("R3 invalidated", 16'h0064);

        // R1: write coincident with lookup sees old value, next sees new
        @(negedge clk);
        bar_wr_en = 1'b1; bar_wr_idx = 3'd6; bar_wr_data = mk_bar(16'h0300, 1'b1, 6'h09, 8'h00);
        io_valid = 1'b1; io_addr = 16'h0300;
        @(negedge clk);
        check("R1 old value", 16'h0000, 16'h0300);
        model_bar[6] = mk_bar(16'h0300, 1'b1, 6'h09, 8'h00);
        bar_wr_en = 1'b0;
        @(negedge clk);
        io_valid = 1'b0;
        check("R1 new value", {1'b1, 1'b0, 1'b1, 6'h09, 7'h00}, 16'h0300);
        // R6 explicit device number
        lookup("R6 dev", 16'h0300);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule